// File: doc/BRIEF.md
# Scan-Line Display List Controller

This block drives a raster display from a chain of descriptors held in main memory instead of a single frame buffer. Every descriptor covers a band of consecutive scan lines and gives that band its own left offset, line width in words, pixel doubling and polarity. A fixed timing generator produces the line and frame blanking. During each horizontal blank the engine walks the chain as far as it needs to, then prefetches the words of the line into a four-word line buffer. During the visible part of the line it serialises those words to a one-bit pixel stream.

A 16-pixel cursor pattern is merged into the stream at a programmable column on every visible line. Memory is reached through a plain word-read port. The request and address are driven by the block. The memory answers with an acknowledge and the data word in the same cycle, and may hold the acknowledge low to stall.

A descriptor is four consecutive words: the link to the next descriptor, the band control word, the start address of the band's first line, and the band's line count. The control word packs bit 15 = half resolution, bit 14 = invert, bits 13:8 = left offset in 16-pixel units, and bits 7:0 = words per line.

Top module: `scanline_display_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `pix_valid` and `pix` are low. The first frame after reset starts from the descriptor at `list_head`.
- R2: A band with line count N fills N consecutive visible lines. The following line uses the descriptor named by the link word. A zero link ends the chain, and every remaining visible line of the frame shows 0.
- R3: Within a band, the first 16 × offset pixels of each line show the background value: 0, or 1 when invert is set.
- R4: A band line shows the words that start at the band's current line address, most significant bit first. The line address advances by the word count after each line. Bit 0 of the word count is ignored, so the count is always even. Pixels past the last word show background.
- R5: With invert set, each displayed data bit and the background appear complemented.
- R6: With half resolution set, each data bit occupies two adjacent pixels, and a word covers 32 pixels.
- R7: When `cursor_x` is not all ones, pixels `cursor_x` to `cursor_x`+15 are XORed with `cursor_pat`, bit 15 first. Columns past the visible width are dropped.
- R8: `cursor_x` = 16'hFFFF removes the cursor from every line.
- R9: A word that has not arrived in the line buffer by the time it is due is shown as background.
- R10: A descriptor with line count 0 covers no line. Its link is followed within the same blanking interval.
- R11: A word request is raised only while the line buffer has room for at least two words, and the buffer never holds more than its depth.
- R12: Each frame has exactly V_ACTIVE × H_ACTIVE valid pixels. `pix_valid` is never high together with `hsync` or `vsync`.
- R13: No memory request is made while `vsync` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| list_head | input | 16 | Address of the first descriptor of each frame |
| cursor_x | input | 16 | Cursor column; all ones hides the cursor |
| cursor_pat | input | 16 | Cursor pixel pattern, bit 15 leftmost |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 16 | Word read address |
| mem_ack | input | 1 | Memory accepts the request and returns data this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| pix | output | 1 | Pixel value |
| pix_valid | output | 1 | High on visible pixels |
| hsync | output | 1 | Horizontal blanking interval |
| vsync | output | 1 | Vertical blanking lines |

## Verification
A two-band chain that ends early checks the band-to-band handover and the line address advance. It also shows that the lines after a zero link are blank, as opposed to repeated. Separate chains then vary one field at a time against distinct per-word data: the offset, an odd word count, a width wider than the screen, half resolution with invert, and a zero-length descriptor. A mismatch in any of these shows up as a shifted, stretched or inverted bit position. Cursor runs place the pattern in mid-line and at the right edge, and also hide it, so overlay alignment and clipping are seen separately from band data. A run where memory never acknowledges data addresses, while descriptors still load, separates underrun handling from an empty chain.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  localparam int WORD_W = 16;
  localparam int DESC_WORDS = 4;

  typedef struct packed {
    logic       half;
    logic       inv;
    logic [5:0] tab;
    logic [7:0] nwords;
  } band_ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_DESC, ST_SETUP, ST_LINE
  } fetch_state_t;
endpackage

// File: rtl/dlc_timing.sv
module dlc_timing #(
  parameter int H_ACTIVE = 64,
  parameter int H_BLANK  = 16,
  parameter int V_ACTIVE = 6,
  parameter int V_BLANK  = 2,
  parameter int XW       = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic          line_start,
  output logic          frame_start,
  output logic          line_act,
  output logic          hblank,
  output logic          active,
  output logic [XW-1:0] x
);
  localparam int H_TOTAL = H_ACTIVE + H_BLANK;
  localparam int V_TOTAL = V_ACTIVE + V_BLANK;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= VW'(V_TOTAL - 1);
    end else if (hcnt == HW'(H_TOTAL - 1)) begin
      hcnt <= '0;
      vcnt <= (vcnt == VW'(V_TOTAL - 1)) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign line_start  = (hcnt == '0);
  assign frame_start = line_start && (vcnt == VW'(V_TOTAL - 1));
  assign line_act    = (vcnt < VW'(V_ACTIVE));
  assign hblank      = (hcnt < HW'(H_BLANK));
  assign active      = line_act && !hblank;
  assign x           = XW'(hcnt) - XW'(H_BLANK);
endmodule

// File: rtl/dlc_fetch.sv
module dlc_fetch
  import dlc_pkg::*;
#(
  parameter int FD = 4,
  localparam int W  = WORD_W,
  localparam int PW = $clog2(FD),
  localparam int LW = $clog2(FD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  list_head,
  input  logic          line_start,
  input  logic          frame_start,
  input  logic          line_act,
  output logic          mem_req,
  output logic [W-1:0]  mem_addr,
  input  logic          mem_ack,
  input  logic [W-1:0]  mem_rdata,
  input  logic          pop,
  output logic [W-1:0]  head_word,
  output logic          buf_empty,
  output logic [LW-1:0] level,
  output logic          band_on,
  output band_ctl_t     ctl
);
  fetch_state_t   state;
  logic [W-1:0]   dcb_ptr, dcb_base, lines_left, line_addr, fetch_addr;
  logic [7:0]     fetch_left;
  logic [1:0]     idx;
  logic [7:0]     nw;
  logic [W-1:0]   buf_mem [FD];
  logic [PW-1:0]  wp, rp;
  logic           push;

  assign nw = {ctl.nwords[7:1], 1'b0};
  assign mem_req = (state == ST_DESC) ||
                   (state == ST_LINE && fetch_left != 8'd0 && level <= LW'(FD - 2));
  assign mem_addr = (state == ST_DESC) ? dcb_base + W'(idx) : fetch_addr;
  assign push = (state == ST_LINE) && mem_req && mem_ack && !line_start;
  assign head_word = buf_mem[rp];
  assign buf_empty = (level == '0);

  // Line buffer storage: no reset, single write port.
  always_ff @(posedge clk) begin
    if (push) buf_mem[wp] <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      wp <= '0;
      rp <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
      level <= level + LW'(push) - LW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      dcb_ptr <= '0;
      dcb_base <= '0;
      lines_left <= '0;
      line_addr <= '0;
      fetch_addr <= '0;
      fetch_left <= '0;
      idx <= '0;
      band_on <= 1'b0;
      ctl <= '0;
    end else if (line_start) begin
      state <= line_act ? ST_DECIDE : ST_IDLE;
      if (frame_start) begin
        dcb_ptr <= list_head;
        lines_left <= '0;
        band_on <= 1'b0;
      end
    end else begin
      case (state)
        ST_DECIDE: begin
          if (lines_left != '0) begin
            state <= ST_SETUP;
          end else if (dcb_ptr != '0) begin
            dcb_base <= dcb_ptr;
            idx <= '0;
            state <= ST_DESC;
          end else begin
            band_on <= 1'b0;
            state <= ST_IDLE;
          end
        end
        ST_DESC: if (mem_ack) begin
          idx <= idx + 1'b1;
          case (idx)
            2'd0: dcb_ptr <= mem_rdata;
            2'd1: ctl <= band_ctl_t'(mem_rdata);
            2'd2: line_addr <= mem_rdata;
            default: begin
              lines_left <= mem_rdata;
              if (mem_rdata != '0) begin
                state <= ST_SETUP;
              end else if (dcb_ptr != '0) begin
                dcb_base <= dcb_ptr;
                idx <= '0;
              end else begin
                band_on <= 1'b0;
                state <= ST_IDLE;
              end
            end
          endcase
        end
        ST_SETUP: begin
          band_on <= 1'b1;
          fetch_addr <= line_addr;
          fetch_left <= nw;
          line_addr <= line_addr + W'(nw);
          lines_left <= lines_left - 1'b1;
          state <= ST_LINE;
        end
        ST_LINE: if (push) begin
          fetch_addr <= fetch_addr + 1'b1;
          fetch_left <= fetch_left - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dlc_pixel.sv
module dlc_pixel
  import dlc_pkg::*;
#(
  localparam int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         line_start,
  input  logic         active,
  input  logic [W-1:0] x,
  input  logic         band_on,
  input  band_ctl_t    ctl,
  input  logic [W-1:0] head_word,
  input  logic         buf_empty,
  input  logic [W-1:0] cursor_x,
  input  logic [W-1:0] cursor_pat,
  output logic         pop,
  output logic         pix_d
);
  logic [W-1:0] word_reg, word_now, dx;
  logic [4:0]   pc, pc_now;
  logic [3:0]   bit_idx;
  logic [7:0]   shown, nw;
  logic         have, in_band, load, show, last, dbit, cbit, chit;

  assign nw      = {ctl.nwords[7:1], 1'b0};
  assign in_band = active && band_on && (x >= W'({ctl.tab, 4'b0000}));
  assign load    = in_band && !have && (shown < nw);
  assign pop     = load && !buf_empty;
  assign word_now = load ? (buf_empty ? '0 : head_word) : word_reg;
  assign pc_now  = load ? 5'd0 : pc;
  assign show    = in_band && (have || load);
  assign bit_idx = ctl.half ? pc_now[4:1] : pc_now[3:0];
  assign last    = ctl.half ? (pc_now == 5'd31) : (pc_now == 5'd15);
  assign dbit    = show && word_now[4'd15 - bit_idx];

  assign dx   = x - cursor_x;
  assign chit = active && (cursor_x != '1) && (x >= cursor_x) && (dx < W'(16));
  assign cbit = chit && cursor_pat[4'd15 - dx[3:0]];

  assign pix_d = dbit ^ (band_on && ctl.inv) ^ cbit;

  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      have <= 1'b0;
      pc <= '0;
      shown <= '0;
      word_reg <= '0;
    end else if (show) begin
      word_reg <= word_now;
      pc <= pc_now + 1'b1;
      have <= !last;
      if (load) shown <= shown + 1'b1;
    end
  end
endmodule

// File: rtl/scanline_display_ctrl.sv
module scanline_display_ctrl
  import dlc_pkg::*;
#(
  parameter int H_ACTIVE   = 64,
  parameter int H_BLANK    = 16,
  parameter int V_ACTIVE   = 6,
  parameter int V_BLANK    = 2,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] list_head,
  input  logic [15:0] cursor_x,
  input  logic [15:0] cursor_pat,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata,
  output logic        pix,
  output logic        pix_valid,
  output logic        hsync,
  output logic        vsync
);
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  logic            line_start, frame_start, line_act, hblank, active;
  logic [15:0]     x, head_word;
  logic            buf_empty, band_on, pop, pix_d;
  logic [LW-1:0]   fifo_level;
  band_ctl_t       ctl;

  dlc_timing #(
    .H_ACTIVE(H_ACTIVE), .H_BLANK(H_BLANK),
    .V_ACTIVE(V_ACTIVE), .V_BLANK(V_BLANK), .XW(WORD_W)
  ) u_timing (
    .clk, .rst, .line_start, .frame_start, .line_act, .hblank, .active, .x
  );

  dlc_fetch #(.FD(FIFO_DEPTH)) u_fetch (
    .clk, .rst, .list_head, .line_start, .frame_start, .line_act,
    .mem_req, .mem_addr, .mem_ack, .mem_rdata, .pop,
    .head_word, .buf_empty, .level(fifo_level), .band_on, .ctl
  );

  dlc_pixel u_pixel (
    .clk, .rst, .line_start, .active, .x, .band_on, .ctl,
    .head_word, .buf_empty, .cursor_x, .cursor_pat, .pop, .pix_d
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix <= 1'b0;
      pix_valid <= 1'b0;
      hsync <= 1'b0;
      vsync <= 1'b0;
    end else begin
      pix <= active && pix_d;
      pix_valid <= active;
      hsync <= hblank;
      vsync <= !line_act;
    end
  end
endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
  parameter int FD = 4,
  localparam int LW = $clog2(FD + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_valid,
  input logic          hsync,
  input logic          vsync,
  input logic          mem_req,
  input logic [LW-1:0] level
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    rst |=> !pix_valid);

  assert_valid_outside_blank_R12: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (!hsync && !vsync));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(FD));

  assert_request_needs_room_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (level <= LW'(FD - 2)));

  assert_no_fetch_in_vblank_R13: assert property (@(posedge clk) disable iff (rst)
    vsync |-> !mem_req);
endmodule

bind scanline_display_ctrl dlc_checker #(.FD(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .pix_valid(pix_valid), .hsync(hsync), .vsync(vsync),
  .mem_req(mem_req), .level(fifo_level)
);

// File: tb/scanline_display_ctrl_bench.sv
module scanline_display_ctrl_bench;
  localparam int HA = 64, HB = 16, VA = 6, VB = 2;
  localparam int FRAME = (HA + HB) * (VA + VB);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] list_head = '0, cursor_x = 16'hFFFF, cursor_pat = '0;
  logic        mem_req, mem_ack, pix, pix_valid, hsync, vsync;
  logic [15:0] mem_addr, mem_rdata;
  logic        starve = 1'b0;
  logic [15:0] mem [0:255];

  int vectors = 0, errors = 0, pix_seen = 0;
  string cur_req = "R2";
  logic exp_q [$];

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];
  assign mem_ack   = !starve || (mem_addr < 16'h0040);

  scanline_display_ctrl u_scanline_display_ctrl (
    .clk, .rst, .list_head, .cursor_x, .cursor_pat,
    .mem_req, .mem_addr, .mem_ack, .mem_rdata,
    .pix, .pix_valid, .hsync, .vsync
  );

  // Monitor: pop expected pixel for every valid output pixel.
  always @(negedge clk) begin
    if (!rst && pix_valid) begin
      vectors++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12 (%s) extra pixel: got %0b expected none", cur_req, pix);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (pix !== e) begin
          errors++;
          $display("FAIL %s pixel %0d (line %0d col %0d): got %0b expected %0b",
                   cur_req, pix_seen, (pix_seen / HA) % VA, pix_seen % HA, pix, e);
        end
      end
      pix_seen++;
    end
  end

  // Expected frame from the requirements.
  task automatic push_frame();
    logic [15:0] ptr, c, la, left;
    logic band;
    ptr = list_head; left = 0; band = 0; c = 0; la = 0;
    for (int ln = 0; ln < VA; ln++) begin
      int nw, tab;
      if (left == 0) begin
        band = 0;
        while (ptr != 0) begin
          logic [15:0] b;
          b = ptr;
          ptr = mem[b[7:0]];
          if (mem[8'(b + 3)] != 0) begin
            c = mem[8'(b + 1)]; la = mem[8'(b + 2)]; left = mem[8'(b + 3)];
            band = 1;
            break;
          end
        end
      end
      nw = int'(c[7:1]) * 2;
      tab = int'(c[13:8]) * 16;
      for (int x = 0; x < HA; x++) begin
        logic d;
        if (!band) d = 0;
        else if (x < tab) d = c[14];
        else begin
          int k, w, bi;
          logic [15:0] wd;
          k = x - tab;
          w = c[15] ? k / 32 : k / 16;
          bi = c[15] ? (k % 32) / 2 : k % 16;
          wd = (w < nw && !starve) ? mem[8'(la + w)] : 16'h0;
          d = wd[15 - bi] ^ c[14];
        end
        if (cursor_x != 16'hFFFF && x >= cursor_x && x < int'(cursor_x) + 16)
          d = d ^ cursor_pat[15 - (x - cursor_x)];
        exp_q.push_back(d);
      end
      if (band) begin
        la = la + 16'(nw);
        left = left - 1;
      end
    end
  endtask

  task automatic run_case(input string req, input int frames);
    @(posedge clk); #2;
    rst = 1'b1;
    cur_req = req;
    repeat (2) @(posedge clk);
    #2;
    exp_q.delete();
    pix_seen = 0;
    for (int f = 0; f < frames; f++) push_frame();
    rst = 1'b0;
    repeat (FRAME * frames + 20) @(posedge clk);
    #2;
    rst = 1'b1;
    vectors++;
    if (exp_q.size() != 0 || pix_seen != frames * VA * HA) begin
      errors++;
      $display("FAIL R12 (%s) valid pixel count: got %0d expected %0d",
               req, pix_seen, frames * VA * HA);
    end
  endtask

  task automatic set_desc(input int a, input logic [15:0] nxt, ctl,
                          start, cnt);
    mem[a] = nxt; mem[a + 1] = ctl; mem[a + 2] = start; mem[a + 3] = cnt;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 40503) ^ 16'h5A5A;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    if (pix_valid !== 1'b0 || pix !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: got valid=%0b pix=%0b expected 0 0", pix_valid, pix);
    end

    // R2 R4: two bands then end of chain, two frames
    set_desc(8'h10, 16'h0020, 16'h0002, 16'h0040, 16'd2);
    set_desc(8'h20, 16'h0000, 16'h0002, 16'h0050, 16'd2);
    list_head = 16'h0010;
    run_case("R2", 2);

    // R3: left offset of two units
    set_desc(8'h10, 16'h0000, 16'h0202, 16'h0060, 16'd6);
    run_case("R3", 1);

    // R4: odd count treated as even, and width beyond the screen
    set_desc(8'h10, 16'h0020, 16'h0003, 16'h0040, 16'd3);
    set_desc(8'h20, 16'h0000, 16'h0006, 16'h0080, 16'd3);
    run_case("R4", 1);

    // R5 R6: half resolution with invert
    set_desc(8'h10, 16'h0000, 16'hC002, 16'h0070, 16'd6);
    run_case("R5_R6", 1);

    // R10: zero-length descriptor skipped
    set_desc(8'h10, 16'h0020, 16'h0002, 16'h0040, 16'd0);
    set_desc(8'h20, 16'h0030, 16'h4002, 16'h0090, 16'd3);
    set_desc(8'h30, 16'h0000, 16'h0104, 16'h00A0, 16'd2);
    run_case("R10", 1);

    // R7: cursor mid-line, then clipped at the right edge
    set_desc(8'h10, 16'h0000, 16'h0004, 16'h0040, 16'd6);
    cursor_x = 16'd10; cursor_pat = 16'hF00F;
    run_case("R7", 1);
    cursor_x = 16'd56; cursor_pat = 16'hA5C3;
    run_case("R7", 1);

    // R8: all-ones column hides the cursor
    cursor_x = 16'hFFFF; cursor_pat = 16'hFFFF;
    run_case("R8", 1);

    // R9: data words never acknowledged; descriptors still load
    set_desc(8'h10, 16'h0000, 16'h4004, 16'h0040, 16'd6);
    cursor_x = 16'd20; cursor_pat = 16'h8001;
    starve = 1'b1;
    run_case("R9", 1);
    starve = 1'b0;

    // R11 R13: data fully delivered in the runs above proves no buffer loss
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule